// File: doc/BRIEF.md
# Programmable Square-Wave Generator

This block turns a bus clock into a slow, programmable square wave. A fixed prescaler divides the bus clock into coarse ticks. A reload counter then counts those ticks and, in the toggle mode, inverts the output level once per programmed half period. Software programs the generator with a single write that carries three fields: a reload value, a mode code and a diagnostic bit. Every write restarts the timing from a known point, so the first half period after a write is always exact.

The live output level can be read back next to the stored fields. Software can therefore time edges of the wave against its own reference clock and work out the bus frequency from the result. The wave reaches the pad only when both the pin-direction bit and the output-enable bit are set. Any mode code other than the toggle code holds the output low.

Top module: `sqw_gen`

## Requirements
- R1: One tick spans PRESCALE bus clocks (default 520). With reload value 0 in toggle mode, the level changes exactly every PRESCALE clocks after a write.
- R2: Mode code 3'b111 is toggle mode. After a write, the level starts low and inverts every (reload+1) ticks. The first inversion falls exactly (reload+1)*PRESCALE clock edges after the write edge, so one full period is 2*(reload+1) ticks.
- R3: While reset is held and after it is released, the level, the pad data, the pad enable and all read-back fields are zero.
- R4: A write with all fields zero brings the block back to its reset state: level low, fields zero and timing restarted.
- R5: A write in the middle of a half period discards the partial count. The next inversion then comes a full (reload+1)*PRESCALE clocks after that write.
- R6: With any mode code other than 3'b111, the level stays low on every cycle.
- R7: `rd_count`, `rd_mode` and `rd_diag` show the fields of the last write from the cycle after the write edge. `rd_level` shows the live output level.
- R8: `pad_oe` is `dir_pin0 & out_en`. `pad_out` equals the level when `pad_oe` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_count | input | COUNT_W | Reload value (half period in ticks, minus one) |
| wr_mode | input | 3 | Mode code; 3'b111 toggles |
| wr_diag | input | 1 | Diagnostic bit, stored and read back |
| dir_pin0 | input | 1 | Pin 0 direction bit (1 = drive) |
| out_en | input | 1 | Output enable for the wave |
| rd_count | output | COUNT_W | Stored reload value |
| rd_mode | output | 3 | Stored mode code |
| rd_diag | output | 1 | Stored diagnostic bit |
| rd_level | output | 1 | Live output level |
| pad_out | output | 1 | Data to the pad |
| pad_oe | output | 1 | Pad drive enable |

## Verification
Four properties hold on every cycle:
- ticks come exactly PRESCALE clocks apart, counted from the last write or tick;
- the level changes only on a half-period boundary or a write;
- the level stays low outside toggle mode;
- the pad is gated by its enable, and a write always leaves the level low.

Several behaviours depend on a long window of history and can only be shown by the bench's scenarios against its reference model:
- the exact edge count from a write to each inversion for several reload values;
- the restart on a mid-period rewrite;
- the return to the reset state after a zero write.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'b111;

  function automatic logic is_toggle(input logic [MODE_W-1:0] m);
    return m == MODE_TOGGLE;
  endfunction

  // Clock edges from a write to the first inversion.
  function automatic longint unsigned half_clocks(input longint unsigned reload,
                                                  input longint unsigned prescale);
    return (reload + 1) * prescale;
  endfunction
endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
  parameter int unsigned PRESCALE = 520
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else if (tick)         pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/sqw_half_counter.sv
module sqw_half_counter #(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  input  logic [COUNT_W-1:0] limit,
  output logic               half_wrap
);
  logic [COUNT_W-1:0] cnt_q;
  logic               at_limit;

  assign at_limit  = (cnt_q == limit);
  assign half_wrap = tick & at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (tick)         cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sqw_cfg_reg.sv
module sqw_cfg_reg
  import sqw_pkg::*;
#(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic [MODE_W-1:0]  wr_mode,
  input  logic               wr_diag,
  output logic [COUNT_W-1:0] cfg_count,
  output logic [MODE_W-1:0]  cfg_mode,
  output logic               cfg_diag,
  output logic               restart
);
  assign restart = wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_count <= '0;
      cfg_mode  <= '0;
      cfg_diag  <= 1'b0;
    end else if (wr_en) begin
      cfg_count <= wr_count;
      cfg_mode  <= wr_mode;
      cfg_diag  <= wr_diag;
    end
  end
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int unsigned PRESCALE = 520,
  parameter int unsigned COUNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic [2:0]         wr_mode,
  input  logic               wr_diag,
  input  logic               dir_pin0,
  input  logic               out_en,
  output logic [COUNT_W-1:0] rd_count,
  output logic [2:0]         rd_mode,
  output logic               rd_diag,
  output logic               rd_level,
  output logic               pad_out,
  output logic               pad_oe
);
  logic restart;
  logic tick;
  logic half_wrap;
  logic toggle_sel;
  logic flip;
  logic level_q;

  sqw_cfg_reg #(.COUNT_W(COUNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_count(wr_count),
    .wr_mode(wr_mode), .wr_diag(wr_diag), .cfg_count(rd_count),
    .cfg_mode(rd_mode), .cfg_diag(rd_diag), .restart(restart)
  );

  sqw_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  sqw_half_counter #(.COUNT_W(COUNT_W)) u_half (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(rd_count), .half_wrap(half_wrap)
  );

  assign toggle_sel = is_toggle(rd_mode);
  assign flip       = half_wrap & toggle_sel;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) level_q <= 1'b0;
    else if (!toggle_sel)  level_q <= 1'b0;
    else if (flip)         level_q <= ~level_q;
  end

  assign rd_level = level_q;
  assign pad_oe   = dir_pin0 & out_en;
  assign pad_out  = level_q & pad_oe;
endmodule

// File: rtl/sqw_gen_checker.sv
module sqw_gen_checker #(
  parameter int unsigned PRESCALE = 520
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] rd_mode,
  input logic       rd_level,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       tick,
  input logic       flip
);
  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en || tick) gap_q <= 0;
    else                         gap_q <= gap_q + 1;
  end

  // R1: ticks are exactly PRESCALE clocks apart
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == PRESCALE - 1));

  // R2: the level changes only at a half-period boundary or a write
  a_r2_change_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_level != $past(rd_level)) |-> ($past(flip) || $past(wr_en)));

  // R4: the level is low after any write
  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_level);

  // R6: the level stays low outside toggle mode
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode != 3'b111) |-> !rd_level);

  // R8: the pad data is gated by the pad enable
  a_r8_pad_gate: assert property (@(posedge clk) disable iff (!rst_n)
    pad_out |-> (pad_oe && rd_level));
endmodule

bind sqw_gen sqw_gen_checker #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_mode(rd_mode),
  .rd_level(rd_level), .pad_out(pad_out), .pad_oe(pad_oe),
  .tick(tick), .flip(flip)
);

// File: tb/test_sqw_gen.sv
`timescale 1ns/1ps
module test_sqw_gen;
  localparam int P  = 520;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_count = '0;
  logic [2:0]    wr_mode = '0;
  logic          wr_diag = 1'b0;
  logic          dir_pin0 = 1'b0;
  logic          out_en = 1'b0;
  logic [CW-1:0] rd_count;
  logic [2:0]    rd_mode;
  logic          rd_diag;
  logic          rd_level;
  logic          pad_out;
  logic          pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Reference model state: fields and edges since the last write or reset.
  longint m_k = 0;
  int     m_count = 0;
  int     m_mode = 0;
  int     m_diag = 0;
  bit     model_on = 0;

  always #2 clk = ~clk;

  sqw_gen #(.PRESCALE(P), .COUNT_W(CW)) i_sqw_gen (.*);

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_k = 0; m_count = 0; m_mode = 0; m_diag = 0;
    end else if (wr_en) begin
      m_k = 0; m_count = wr_count; m_mode = wr_mode; m_diag = wr_diag;
    end else begin
      m_k++;
    end
    model_on = 1;
  end

  function automatic bit exp_level();
    longint half;
    if (m_mode != 7) return 1'b0;
    half = longint'(m_count + 1) * P;
    return ((m_k / half) % 2) == 1;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (model_on) begin
      chk(m_mode == 7 ? "R2" : "R6", "level", rd_level, exp_level());
      chk("R7", "count", rd_count, m_count);
      chk("R7", "mode", rd_mode, m_mode);
      chk("R7", "diag", rd_diag, m_diag);
      chk("R8", "pad_oe", pad_oe, dir_pin0 & out_en);
      chk("R8", "pad_out", pad_out, exp_level() & dir_pin0 & out_en);
    end
  end

  task automatic do_write(input int cnt, input int mode, input bit diag);
    @(negedge clk);
    wr_en = 1'b1; wr_count = CW'(cnt); wr_mode = 3'(mode); wr_diag = diag;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R3", "level in reset", rd_level, 0);
    chk("R3", "pad_oe in reset", pad_oe, 0);
    chk("R3", "count in reset", rd_count, 0);
    rst_n = 1'b1;
    repeat (600) @(negedge clk);
    chk("R3", "level after reset", rd_level, 0);

    dir_pin0 = 1'b1; out_en = 1'b1;
    // R1: reload 0 gives an inversion every P clocks
    do_write(0, 7, 1'b1);
    repeat (P - 1) @(negedge clk);
    chk("R1", "low before first tick", rd_level, 0);
    @(negedge clk);
    chk("R1", "high at first tick", rd_level, 1);
    repeat (P) @(negedge clk);
    chk("R1", "low at second tick", rd_level, 0);
    repeat (2000) @(negedge clk);

    // R2: reload 2 gives a half period of 3 ticks
    do_write(2, 7, 1'b0);
    repeat (3 * P - 1) @(negedge clk);
    chk("R2", "low before half period", rd_level, 0);
    @(negedge clk);
    chk("R2", "high at half period", rd_level, 1);
    repeat (3 * P) @(negedge clk);
    chk("R2", "low after full period", rd_level, 0);
    repeat (1000) @(negedge clk);

    // R5: a rewrite mid-period restarts the count
    do_write(1, 7, 1'b0);
    repeat (700) @(negedge clk);
    do_write(1, 7, 1'b1);
    repeat (2 * P - 1) @(negedge clk);
    chk("R5", "low before restarted half", rd_level, 0);
    @(negedge clk);
    chk("R5", "high at restarted half", rd_level, 1);

    // R6: other modes hold the level low
    do_write(0, 3, 1'b1);
    repeat (2500) @(negedge clk);
    chk("R6", "mode 3 level", rd_level, 0);
    do_write(0, 6, 1'b0);
    repeat (1200) @(negedge clk);
    chk("R6", "mode 6 level", rd_level, 0);

    // R8: pad gating while the level is high
    do_write(0, 7, 1'b0);
    repeat (P + 10) @(negedge clk);
    chk("R8", "level high for gating", rd_level, 1);
    dir_pin0 = 1'b0; @(negedge clk);
    chk("R8", "pad off without dir", pad_out, 0);
    dir_pin0 = 1'b1; out_en = 1'b0; @(negedge clk);
    chk("R8", "pad off without enable", pad_oe, 0);
    out_en = 1'b1; @(negedge clk);
    chk("R8", "pad follows level", pad_out, 1);

    // R4: an all-zero write returns to the reset state
    do_write(0, 0, 1'b0);
    chk("R4", "level", rd_level, 0);
    chk("R4", "mode", rd_mode, 0);
    chk("R4", "diag", rd_diag, 0);
    repeat (3 * P) @(negedge clk);
    chk("R4", "level stays low", rd_level, 0);

    finish_run();
  end
endmodule